// File: doc/BRIEF.md
# Destination-Chain DMA Tag Sequencer

This block steers one DMA channel that copies quadwords from a scratch source to a destination. The source stream describes itself: every data packet is preceded by a 128-bit tag. The tag gives a packet type, an interrupt flag, a destination address and a quadword count. The sequencer fetches a tag at the current scratch address and decodes it. It loads the destination pointer and the count, then drives one beat per quadword to a simple data mover. After each packet it either reads the next tag or closes the channel.

A channel can be started with a count that is already non-zero. In that case the pending packet moves first. If the preloaded packet type was the terminating type, no tag is read at all. One packet type also publishes the end address of its packet. A downstream stall-control stage compares against that address when it has selected this channel. At completion the channel drops its busy flag and gives a one-cycle interrupt. A tag whose type is not recognised ends the chain and sets an error flag.

Top module: `dcs_seq`

## Requirements
- R1: After reset, busy, irq, err, tag_req and mv_valid are 0, and stall_addr is 0.
- R2: A tag is requested at the current scratch pointer, which starts at init_src. The pointer advances by 16 for each tag taken (tag_req and tag_vld high at a clock edge) and by 16 for each quadword moved. tag_req and tag_addr hold until the tag is taken.
- R3: The tag's low 64 bits are read as follows. Bits 63:32 hold the destination, bits 15:0 the quadword count, bits 30:28 the type and bit 31 the IRQ flag. Packet beat i carries mv_dst = destination + 16·i, and its mv_src continues from the scratch pointer.
- R4: Type code 1 (count) moves its packet and then fetches the next tag.
- R5: Type code 7 (end) moves its packet and then finishes the chain.
- R6: Type code 0 (count with stall) moves its packet and continues like code 1. If stall_sel is high when the tag is taken, stall_addr becomes destination + count·16. Otherwise stall_addr keeps its value.
- R7: When tie_en is high and the tag's IRQ bit is set, the chain finishes after that tag's packet, whatever its type.
- R8: A non-zero init_qwc at start moves init_qwc quadwords from init_dst/init_src before any tag is read. If init_tag is 7, the chain then finishes with no tag read.
- R9: At completion, irq is high for exactly one cycle and busy is low in that cycle. irq rises once per chain.
- R10: Any other type code finishes the chain without moving data for that tag and sets err. err clears at the next accepted start.
- R11: While mv_valid is high and mv_ready is low, mv_valid, mv_dst and mv_src hold. Each beat accepted while both are high moves one quadword.
- R12: start is ignored while the channel is busy.
- R13: A tag with count 0 moves no data and then follows its type and IRQ rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken when idle |
| tie_en | input | 1 | Channel tag-interrupt enable |
| stall_sel | input | 1 | Stall control has selected this channel |
| init_qwc | input | 16 | Pending quadword count at start |
| init_dst | input | 32 | Destination address at start |
| init_src | input | SAW | Scratch address at start |
| init_tag | input | 3 | Type of the preloaded tag |
| tag_req | output | 1 | Tag fetch request |
| tag_addr | output | SAW | Scratch address of the tag |
| tag_vld | input | 1 | Tag word valid |
| tag_word | input | 64 | Low 64 bits of the tag |
| mv_valid | output | 1 | Data beat request |
| mv_ready | input | 1 | Data mover accepts the beat |
| mv_dst | output | 32 | Destination of the beat |
| mv_src | output | SAW | Scratch source of the beat |
| busy | output | 1 | Channel running (start bit) |
| irq | output | 1 | Channel completion interrupt pulse |
| err | output | 1 | Unknown tag type seen |
| stall_addr | output | 32 | Published stall address |

## Verification
The checker covers the handshake rules on every cycle. A stalled beat keeps its addresses and a pending tag request keeps its address. Tag fetch and data beats never overlap. The interrupt is a single pulse with the channel idle, and no data moves while err is high. The first beat after a tag reads from the scratch word just after that tag. The packet walk itself can only be shown by the bench's scenarios. These cover which types continue or stop, the interrupt-flag override, the preloaded packet, the stall address and an ignored restart. The bench replays each chain in its own model and compares the full beat and tag-address sequences.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int DW      = 32;
  localparam int QW      = 16;
  localparam int TAG_W   = 64;
  localparam int IDW     = 3;
  localparam int QB_SH   = 4;

  localparam logic [IDW-1:0] TY_CSTALL = 3'd0;
  localparam logic [IDW-1:0] TY_COUNT  = 3'd1;
  localparam logic [IDW-1:0] TY_LAST   = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_DONE} st_t;

  typedef struct packed {
    logic [DW-1:0]  dst;
    logic [QW-1:0]  qwc;
    logic [IDW-1:0] ty;
    logic           irq;
    logic           known;
    logic           last;
    logic           cstall;
  } tag_t;

  function automatic logic [DW-1:0] qw_bytes(input logic [QW-1:0] n);
    return DW'(n) << QB_SH;
  endfunction

  function automatic logic [DW-1:0] stall_target(input logic [DW-1:0] d,
                                                 input logic [QW-1:0] n);
    return d + qw_bytes(n);
  endfunction
endpackage

// File: rtl/dcs_tag_decode.sv
module dcs_tag_decode
  import dcs_pkg::*;
(
  input  logic [TAG_W-1:0] word,
  output tag_t             tag
);
  logic unused_rsv;
  assign unused_rsv = ^word[27:16];

  always_comb begin
    tag.dst    = word[63:32];
    tag.qwc    = word[QW-1:0];
    tag.ty     = word[30:28];
    tag.irq    = word[31];
    tag.last   = (word[30:28] == TY_LAST);
    tag.cstall = (word[30:28] == TY_CSTALL);
    tag.known  = tag.last || tag.cstall || (word[30:28] == TY_COUNT);
  end
endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm
  import dcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pend_nz,
  input  logic tag_take,
  input  logic tag_ok,
  input  logic qwc_zero,
  input  logic fin,
  output st_t  state
);
  st_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (start) nxt = pend_nz ? S_XFER : S_FETCH;
      S_FETCH: if (tag_take) nxt = tag_ok ? S_XFER : S_DONE;
      S_XFER:  if (qwc_zero) nxt = fin ? S_DONE : S_FETCH;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int SAW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           tie_en,
  input  logic           stall_sel,
  input  logic [QW-1:0]  init_qwc,
  input  logic [DW-1:0]  init_dst,
  input  logic [SAW-1:0] init_src,
  input  logic [IDW-1:0] init_tag,
  output logic           tag_req,
  output logic [SAW-1:0] tag_addr,
  input  logic           tag_vld,
  input  logic [TAG_W-1:0] tag_word,
  output logic           mv_valid,
  input  logic           mv_ready,
  output logic [DW-1:0]  mv_dst,
  output logic [SAW-1:0] mv_src,
  output logic           busy,
  output logic           irq,
  output logic           err,
  output logic [DW-1:0]  stall_addr
);
  localparam logic [SAW-1:0] SRC_STEP = SAW'(1 << QB_SH);
  localparam logic [DW-1:0]  DST_STEP = DW'(1 << QB_SH);

  st_t            state;
  tag_t           tag;
  logic [DW-1:0]  dst_q;
  logic [SAW-1:0] src_q;
  logic [QW-1:0]  qwc_q;
  logic           fin_q, err_q;
  logic [DW-1:0]  stall_q;

  // named internal events
  logic start_take, tag_take, beat_take, qwc_zero;
  assign start_take = start && (state == S_IDLE);
  assign tag_take   = tag_req && tag_vld;
  assign beat_take  = mv_valid && mv_ready;
  assign qwc_zero   = (qwc_q == '0);

  dcs_tag_decode u_dec (.word(tag_word), .tag(tag));

  dcs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_take),
    .pend_nz(init_qwc != '0), .tag_take(tag_take), .tag_ok(tag.known),
    .qwc_zero(qwc_zero), .fin(fin_q), .state(state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= '0;
      src_q   <= '0;
      qwc_q   <= '0;
      fin_q   <= 1'b0;
      err_q   <= 1'b0;
      stall_q <= '0;
    end else if (start_take) begin
      dst_q <= init_dst;
      src_q <= init_src;
      qwc_q <= init_qwc;
      fin_q <= (init_qwc != '0) && (init_tag == TY_LAST);
      err_q <= 1'b0;
    end else if (tag_take) begin
      src_q <= src_q + SRC_STEP;
      if (tag.known) begin
        dst_q <= tag.dst;
        qwc_q <= tag.qwc;
        fin_q <= tag.last || (tie_en && tag.irq);
        if (tag.cstall && stall_sel) stall_q <= stall_target(tag.dst, tag.qwc);
      end else begin
        err_q <= 1'b1;
      end
    end else if (beat_take) begin
      dst_q <= dst_q + DST_STEP;
      src_q <= src_q + SRC_STEP;
      qwc_q <= qwc_q - 1'b1;
    end
  end

  assign tag_req    = (state == S_FETCH);
  assign tag_addr   = src_q;
  assign mv_valid   = (state == S_XFER) && !qwc_zero;
  assign mv_dst     = dst_q;
  assign mv_src     = src_q;
  assign busy       = (state == S_FETCH) || (state == S_XFER);
  assign irq        = (state == S_DONE);
  assign err        = err_q;
  assign stall_addr = stall_q;
endmodule

// File: rtl/dcs_seq_chk.sv
module dcs_seq_chk #(
  parameter int SAW = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tag_req,
  input logic           tag_vld,
  input logic [SAW-1:0] tag_addr,
  input logic           mv_valid,
  input logic           mv_ready,
  input logic [31:0]    mv_dst,
  input logic [SAW-1:0] mv_src,
  input logic           busy,
  input logic           irq,
  input logic           err,
  input logic           tag_take
);
  a_r11_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_dst) && $stable(mv_src));

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req && !tag_vld |=> tag_req && $stable(tag_addr));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_req && mv_valid));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r9_idle_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && !mv_valid && !tag_req);

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mv_valid);

  a_r3_src_after_tag: assert property (@(posedge clk) disable iff (!rst_n)
    tag_take |=> !mv_valid || (mv_src == $past(tag_addr) + SAW'(16)));
endmodule

bind dcs_seq dcs_seq_chk #(.SAW(SAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tag_req(tag_req), .tag_vld(tag_vld),
  .tag_addr(tag_addr), .mv_valid(mv_valid), .mv_ready(mv_ready),
  .mv_dst(mv_dst), .mv_src(mv_src), .busy(busy), .irq(irq), .err(err),
  .tag_take(tag_take)
);

// File: tb/tb_dcs_seq.sv
`timescale 1ns/1ps
module tb_dcs_seq;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic start = 0, tie_en = 0, stall_sel = 0;
  logic [15:0] init_qwc = 0;
  logic [31:0] init_dst = 0;
  logic [13:0] init_src = 0;
  logic [2:0]  init_tag = 0;
  logic tag_req, tag_vld = 0, mv_valid, mv_ready = 0, busy, irq, err;
  logic [13:0] tag_addr, mv_src;
  logic [63:0] tag_word = 0;
  logic [31:0] mv_dst, stall_addr;

  dcs_seq dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [63:0] tmem [16];
  logic [31:0] exp_dst [64];
  logic [13:0] exp_src [64];
  logic [13:0] exp_tadr[16];
  int exp_n, exp_nt;
  logic exp_err;
  logic [31:0] exp_stall = 0;
  logic [31:0] got_dst [64];
  logic [13:0] got_src [64];
  logic [13:0] got_tadr[16];
  int got_n = 0, got_nt = 0, irq_cnt = 0, cyc = 0;
  logic gate = 0;

  // stub: tag source and data mover, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    gate     = ~gate;
    mv_ready = (cyc % 3) != 2;
    tag_vld  = tag_req && gate;
    tag_word = tmem[tag_addr[7:4]];
    if (tag_req && tag_vld) begin
      if (got_nt < 16) got_tadr[got_nt] = tag_addr;
      got_nt++;
    end
    if (mv_valid && mv_ready) begin
      if (got_n < 64) begin got_dst[got_n] = mv_dst; got_src[got_n] = mv_src; end
      got_n++;
    end
    if (irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit q, input logic [2:0] ty,
                                     input logic [15:0] n, input logic [31:0] d);
    return {d, q, ty, 12'h000, n};
  endfunction

  task automatic model(input logic [15:0] q0, input logic [31:0] d0,
                       input logic [13:0] s0, input logic [2:0] ty0,
                       input bit tie, input bit ss);
    logic [31:0] d; logic [13:0] s; logic [15:0] q; logic [63:0] w; bit fin;
    exp_n = 0; exp_nt = 0; exp_err = 0; s = s0; fin = 0;
    if (q0 != 0) begin
      for (int i = 0; i < q0; i++) begin
        exp_dst[exp_n] = d0 + 32'(16 * i); exp_src[exp_n] = s; s = s + 14'd16; exp_n++;
      end
      fin = (ty0 == 3'd7);
    end
    for (int g = 0; g < 16 && !fin; g++) begin
      w = tmem[s[7:4]];
      exp_tadr[exp_nt] = s; exp_nt++; s = s + 14'd16;
      if (!(w[30:28] == 3'd0 || w[30:28] == 3'd1 || w[30:28] == 3'd7)) begin
        exp_err = 1; fin = 1;
      end else begin
        d = w[63:32]; q = w[15:0];
        if (w[30:28] == 3'd0 && ss) exp_stall = d + {12'h000, q, 4'h0};
        for (int i = 0; i < q; i++) begin
          exp_dst[exp_n] = d + 32'(16 * i); exp_src[exp_n] = s; s = s + 14'd16; exp_n++;
        end
        fin = (w[30:28] == 3'd7) || (tie && w[31]);
      end
    end
  endtask

  task automatic run(input string req, input logic [15:0] q0, input logic [31:0] d0,
                     input logic [13:0] s0, input logic [2:0] ty0,
                     input bit tie, input bit ss, input bit poke);
    bit ok; int k;
    model(q0, d0, s0, ty0, tie, ss);
    @(negedge clk); #1;
    got_n = 0; got_nt = 0; irq_cnt = 0;
    init_qwc = q0; init_dst = d0; init_src = s0; init_tag = ty0;
    tie_en = tie; stall_sel = ss; start = 1;
    @(negedge clk); #1; start = 0;
    k = 0;
    while (irq_cnt == 0 && k < 500) begin
      @(negedge clk); #1; k++;
      if (poke && k == 3) begin  // R12: restart while busy must be ignored
        init_qwc = 16'd5; init_dst = 32'hDEAD0000; init_src = 14'h300; start = 1;
      end else start = 0;
    end
    start = 0;
    chk(k < 500, req, "R9 chain completes", k, 500);
    repeat (2) @(negedge clk); #1;
    chk(irq_cnt == 1, req, "R9 one irq pulse", irq_cnt, 1);
    chk(!busy, req, "R9 busy low after end", busy, 0);
    chk(got_n == exp_n, req, "R3 beat count", got_n, exp_n);
    ok = (got_n == exp_n);
    for (int i = 0; i < exp_n && i < 64; i++)
      if (ok && (got_dst[i] !== exp_dst[i] || got_src[i] !== exp_src[i])) begin
        ok = 0; chk(0, req, "R3 beat dst", got_dst[i], exp_dst[i]);
      end
    if (ok) chk(1, req, "R3 beats", 0, 0);
    chk(got_nt == exp_nt, req, "R2 tag fetch count", got_nt, exp_nt);
    ok = (got_nt == exp_nt);
    for (int i = 0; i < exp_nt && i < 16; i++)
      if (ok && got_tadr[i] !== exp_tadr[i]) begin
        ok = 0; chk(0, req, "R2 tag address", got_tadr[i], exp_tadr[i]);
      end
    chk(err === exp_err, req, "R10 err flag", err, exp_err);
    chk(stall_addr === exp_stall, req, "R6 stall_addr", stall_addr, exp_stall);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] tys [4];
    tys = '{3'd0, 3'd1, 3'd7, 3'd3};
    for (int i = 0; i < 16; i++) tmem[i] = mk(0, 3'd7, 16'd0, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!busy && !irq && !err && !tag_req && !mv_valid, "R1", "idle outputs",
        {busy, irq, err, tag_req, mv_valid}, 0);
    chk(stall_addr == 0, "R1", "stall_addr reset", stall_addr, 0);
    rst_n = 1;

    // R4/R6/R5 chain: count, count-with-stall, end
    tmem[4] = mk(0, 3'd1, 16'd2, 32'h1000);
    tmem[7] = mk(0, 3'd0, 16'd1, 32'h2000);
    tmem[9] = mk(0, 3'd7, 16'd3, 32'h3000);
    run("R4", 16'd0, 32'h0, 14'h040, 3'd0, 0, 1, 0);
    // R6 with stall control not selecting the channel
    tmem[7] = mk(0, 3'd0, 16'd4, 32'h5000);
    tmem[12] = mk(0, 3'd7, 16'd0, 32'h6000);
    run("R6", 16'd0, 32'h0, 14'h040, 3'd0, 0, 0, 0);
    // R8 preloaded end: no tag read
    run("R8", 16'd2, 32'h8000, 14'h040, 3'd7, 0, 0, 0);
    // R8 preloaded count: tag fetched after pending data
    tmem[6] = mk(0, 3'd7, 16'd1, 32'h9000);
    run("R8", 16'd2, 32'h8000, 14'h040, 3'd1, 0, 0, 0);
    // R12 restart ignored while busy
    run("R12", 16'd0, 32'h0, 14'h040, 3'd0, 0, 1, 1);
    // R13 zero-count tag continues
    tmem[4] = mk(0, 3'd1, 16'd0, 32'hA000);
    tmem[5] = mk(0, 3'd7, 16'd2, 32'hB000);
    run("R13", 16'd0, 32'h0, 14'h040, 3'd0, 0, 0, 0);

    // R7/R10/R5 sweep over type, count, irq bit, enable, stall select
    for (int t = 0; t < 4; t++)
      for (int q = 0; q < 4; q++)
        for (int b = 0; b < 4; b++)
          for (int ss = 0; ss < 2; ss++) begin
            for (int i = 0; i < 16; i++) tmem[i] = mk(0, 3'd7, 16'd1, 32'hF000);
            tmem[4] = mk(b[0], tys[t], 16'(q), 32'h100 * (t + 1) + 32'h10000);
            run(tys[t] == 3'd3 ? "R10" : (b == 3 ? "R7" : "R5"),
                16'd0, 32'h0, 14'h040, 3'd0, b[1], ss[0], 0);
          end
    // R10 err clears at next start
    tmem[4] = mk(0, 3'd7, 16'd1, 32'h7000);
    run("R10", 16'd0, 32'h0, 14'h040, 3'd0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule